// File: doc/BRIEF.md
# Two-Phase Folded Symmetric Block FIR Filter

This block is a linear-phase FIR filter that runs at half the sample rate. Each accepted transfer carries two consecutive input samples: the earlier one on the even lane and the later one on the odd lane. Each output transfer returns the two matching filter outputs. The coefficient set is fixed at elaboration. It must be mirror-symmetric and have an even tap count of at least four.

The taps are split into even-index and odd-index halves, called E and O. The filter is built from three half-length subfilters:
- E+O, driven by the lane sum. Its coefficients are mirror-symmetric.
- E−O, driven by the lane difference. Its coefficients are mirror-antisymmetric.
- O alone, driven by the odd lane.

The first two subfilters fold mirrored taps together before a shared multiplier, so each needs half as many products as it has taps. The combination stage works as follows:
- The odd output is half the difference of the two folded subfilter results.
- The even output is half their sum, minus the O-subfilter result of the current block, plus the O-subfilter result of the previous block.

The input side uses valid/ready handshakes and so does the output side. A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is taken on a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the single output register is empty or is being drained in the same cycle. Holding `out_ready` low therefore stalls the whole filter. While stalled, the filter history does not move and the held result does not change.

Top module: `fir2_symm_ffa`

## Requirements
- R1: The even output of block n equals the sum over j of h[j]·x[2n−j], where x[2n] is the even-lane sample of block n and x[2n+1] is the odd-lane sample.
- R2: The odd output of block n equals the sum over j of h[j]·x[2n+1−j].
- R3: Reset clears every history sample and the block-delay register to zero, and drives `out_valid` low. The first outputs after reset are therefore computed as if all earlier input samples were zero.
- R4: An accepted transfer makes `out_valid` high on the next rising edge. `out_valid` falls on the edge after a result is taken if no new transfer was accepted on that edge.
- R5: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_y0` and `out_y1` keep their values on the next edge.
- R6: Cycles without an accepted transfer leave the history untouched. Input gaps and back-pressure of any pattern therefore give the same output sequence as back-to-back transfers.
- R7: Halving is exact, because the sum and the difference of the two folded results are always even. Full-scale inputs of either sign give exact results within the `OW`-bit outputs.
- R8: A single unit sample on the even lane of the first block after reset, followed by zero blocks, returns the coefficients in index order: block k gives h[2k] on the even lane and h[2k+1] on the odd lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair is offered |
| in_ready | output | 1 | Filter can accept a pair this cycle |
| in_x0 | input | DW | Earlier (even-phase) sample, signed |
| in_x1 | input | DW | Later (odd-phase) sample, signed |
| out_valid | output | 1 | Output pair is held |
| out_ready | input | 1 | Consumer takes the output pair |
| out_y0 | output | OW | Even-phase filter output, signed |
| out_y1 | output | OW | Odd-phase filter output, signed |

## Verification
A misplaced history register, or a sign error in the fold of the antisymmetric subfilter, corrupts the next result that reaches the ports. The bench compares every output pair with a direct convolution, so an impulse shows such a fault within N/2 blocks. A stale or missing block-delay value damages only the even lane, and it does so from the second block after a non-zero odd sample. A history that moves during a stall or a gap leaves the outputs shifted against the reference from the following transfer onward. The bench compares outputs and handshake levels every cycle.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

  typedef enum logic [1:0] {
    SUB_DIRECT = 2'd0,
    SUB_SYM    = 2'd1,
    SUB_ANTI   = 2'd2
  } fold_e;

  // internal word: product of (DW+2)-bit folded sample and (CW+1)-bit
  // combined coefficient, summed over up to N/2 terms, plus headroom
  function automatic int acc_width(input int dw, input int cw, input int n);
    return dw + cw + 4 + $clog2(n);
  endfunction

endpackage

// File: rtl/fir2_pre.sv
module fir2_pre #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x_even,
  input  logic signed [DW-1:0] x_odd,
  output logic signed [DW:0]   x_sum,
  output logic signed [DW:0]   x_dif
);
  logic signed [DW:0] ext_e, ext_o;

  assign ext_e = {x_even[DW-1], x_even};
  assign ext_o = {x_odd[DW-1], x_odd};
  assign x_sum = ext_e + ext_o;
  assign x_dif = ext_e - ext_o;
endmodule

// File: rtl/fir2_subfilt.sv
module fir2_subfilt
  import fir2_pkg::*;
#(
  parameter int              SW   = 17,
  parameter int              CW   = 17,
  parameter int              M    = 4,
  parameter int              AW   = 40,
  parameter fold_e           MODE = SUB_DIRECT,
  parameter logic [M*CW-1:0] COEF = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] s_in,
  output logic signed [AW-1:0] y_out
);
  localparam int NPAIR   = M / 2;
  localparam bit HAS_MID = (M % 2) == 1;
  localparam int NPROD   = (MODE == SUB_DIRECT) ? M
                         : NPAIR + ((HAS_MID && MODE == SUB_SYM) ? 1 : 0);

  logic signed [SW-1:0] hist [M-1];
  logic signed [SW-1:0] tap  [M];
  logic signed [AW-1:0] prod [NPROD];

  assign tap[0] = s_in;
  for (genvar k = 1; k < M; k++) begin : g_tap
    assign tap[k] = hist[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < M-1; k++) hist[k] <= '0;
    end else if (en) begin
      hist[0] <= s_in;
      for (int k = 1; k < M-1; k++) hist[k] <= hist[k-1];
    end
  end

  if (MODE == SUB_DIRECT) begin : g_direct
    for (genvar k = 0; k < M; k++) begin : g_mul
      localparam logic signed [CW-1:0] CK = COEF[k*CW +: CW];
      assign prod[k] = AW'(tap[k]) * AW'(CK);
    end
  end else begin : g_fold
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      localparam logic signed [CW-1:0] CK = COEF[p*CW +: CW];
      logic signed [AW-1:0] pre;
      if (MODE == SUB_SYM) begin : g_add
        assign pre = AW'(tap[p]) + AW'(tap[M-1-p]);
      end else begin : g_sub
        assign pre = AW'(tap[p]) - AW'(tap[M-1-p]);
      end
      assign prod[p] = pre * AW'(CK);
    end
    if (HAS_MID && MODE == SUB_SYM) begin : g_mid
      localparam logic signed [CW-1:0] CM = COEF[NPAIR*CW +: CW];
      assign prod[NPAIR] = AW'(tap[NPAIR]) * AW'(CM);
    end
  end

  always_comb begin
    y_out = '0;
    for (int k = 0; k < NPROD; k++) y_out = y_out + prod[k];
  end

  // R6: history only moves on an accepted transfer
  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hist[0]));
endmodule

// File: rtl/fir2_symm_ffa.sv
module fir2_symm_ffa
  import fir2_pkg::*;
#(
  parameter int                  DW     = 16,
  parameter int                  CW     = 16,
  parameter int                  NTAPS  = 8,
  parameter logic [NTAPS*CW-1:0] COEFS  = {16'sd3, 16'hFFFB, 16'sd12, 16'sd40,
                                           16'sd40, 16'sd12, 16'hFFFB, 16'sd3},
  parameter int                  OW     = DW + CW + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_x0,
  input  logic signed [DW-1:0] in_x1,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_y0,
  output logic signed [OW-1:0] out_y1
);
  localparam int MH  = NTAPS / 2;
  localparam int SCW = CW + 1;
  localparam int AW  = acc_width(DW, CW, NTAPS);

  if ((NTAPS % 2) != 0 || NTAPS < 4) begin : g_bad_len
    $error("tap count must be even and at least 4");
  end
  for (genvar i = 0; i < NTAPS/2; i++) begin : g_symchk
    if (COEFS[i*CW +: CW] != COEFS[(NTAPS-1-i)*CW +: CW]) begin : g_bad
      $error("coefficient set is not mirror-symmetric");
    end
  end

  // kind 0: even+odd, 1: even-odd, 2: odd only
  function automatic logic [MH*SCW-1:0] build_sub(input int kind);
    logic [MH*SCW-1:0] r;
    logic signed [SCW-1:0] e, o;
    r = '0;
    for (int k = 0; k < MH; k++) begin
      e = {COEFS[(2*k+1)*CW-1], COEFS[(2*k)*CW +: CW]};
      o = {COEFS[(2*k+2)*CW-1], COEFS[(2*k+1)*CW +: CW]};
      if (kind == 0)      r[k*SCW +: SCW] = e + o;
      else if (kind == 1) r[k*SCW +: SCW] = e - o;
      else                r[k*SCW +: SCW] = o;
    end
    return r;
  endfunction

  localparam logic [MH*SCW-1:0] C_SUM = build_sub(0);
  localparam logic [MH*SCW-1:0] C_DIF = build_sub(1);
  localparam logic [MH*SCW-1:0] C_ODD = build_sub(2);

  logic                 accept;
  logic signed [DW:0]   x_sum, x_dif;
  logic signed [AW-1:0] y_sum, y_dif, y_odd, odd_dly;
  logic signed [AW-1:0] both_add, both_sub, y0_nx, y1_nx;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fir2_pre #(.DW(DW)) u_pre (
    .x_even (in_x0),
    .x_odd  (in_x1),
    .x_sum  (x_sum),
    .x_dif  (x_dif)
  );

  fir2_subfilt #(.SW(DW+1), .CW(SCW), .M(MH), .AW(AW), .MODE(SUB_SYM),
                 .COEF(C_SUM)) u_sub_sum (
    .clk(clk), .rst_n(rst_n), .en(accept), .s_in(x_sum), .y_out(y_sum));

  fir2_subfilt #(.SW(DW+1), .CW(SCW), .M(MH), .AW(AW), .MODE(SUB_ANTI),
                 .COEF(C_DIF)) u_sub_dif (
    .clk(clk), .rst_n(rst_n), .en(accept), .s_in(x_dif), .y_out(y_dif));

  fir2_subfilt #(.SW(DW), .CW(SCW), .M(MH), .AW(AW), .MODE(SUB_DIRECT),
                 .COEF(C_ODD)) u_sub_odd (
    .clk(clk), .rst_n(rst_n), .en(accept), .s_in(in_x1), .y_out(y_odd));

  assign both_add = y_sum + y_dif;
  assign both_sub = y_sum - y_dif;
  assign y0_nx    = (both_add >>> 1) - y_odd + odd_dly;
  assign y1_nx    = both_sub >>> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_dly   <= '0;
      out_valid <= 1'b0;
      out_y0    <= '0;
      out_y1    <= '0;
    end else if (accept) begin
      odd_dly   <= y_odd;
      out_valid <= 1'b1;
      out_y0    <= y0_nx[OW-1:0];
      out_y1    <= y1_nx[OW-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !accept |=> !out_valid);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y0) && $stable(out_y1));
  p_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (both_add[0] == 1'b0) && (both_sub[0] == 1'b0));
  p_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (y0_nx[AW-1:OW-1] == {(AW-OW+1){y0_nx[OW-1]}}) &&
               (y1_nx[AW-1:OW-1] == {(AW-OW+1){y1_nx[OW-1]}}));
endmodule

// File: tb/fir2_symm_ffa_test.sv
`timescale 1ns/1ps
module fir2_symm_ffa_test;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int N  = 8;
  localparam int OW = DW + CW + $clog2(N);
  localparam logic [N*CW-1:0] HV = {16'sd3, 16'hFFFB, 16'sd12, 16'sd40,
                                    16'sd40, 16'sd12, 16'hFFFB, 16'sd3};
  int h [N] = '{3, -5, 12, 40, 40, 12, -5, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic signed [DW-1:0] in_x0 = '0, in_x1 = '0;
  logic signed [OW-1:0] out_y0, out_y1;

  fir2_symm_ffa #(.DW(DW), .CW(CW), .NTAPS(N), .COEFS(HV), .OW(OW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x0(in_x0), .in_x1(in_x1), .out_valid(out_valid),
    .out_ready(out_ready), .out_y0(out_y0), .out_y1(out_y1));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  longint xs[$];
  longint exp0[$], exp1[$];
  string tag_e = "R1", tag_o = "R2";
  bit prev_acc = 0, prev_ov = 0, prev_or = 0, hold = 0;
  logic signed [OW-1:0] hy0, hy1;

  function automatic longint y_at(int idx);
    longint s = 0;
    for (int j = 0; j < N; j++)
      if (idx - j >= 0) s += longint'(h[j]) * xs[idx-j];
    return s;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(bit iv, logic signed [DW-1:0] a, logic signed [DW-1:0] b, bit ordy);
    bit ov_exp;
    longint e0, e1;
    @(negedge clk);
    in_valid = iv; in_x0 = a; in_x1 = b; out_ready = ordy;
    #1;
    ov_exp = prev_acc || (prev_ov && !prev_or);
    chk(out_valid == ov_exp, "R4", out_valid, ov_exp);
    if (hold) chk(out_valid && out_y0 == hy0 && out_y1 == hy1, "R5", out_y0, hy0);
    chk(in_ready == (!out_valid || out_ready), "R5", in_ready, !out_valid || out_ready);
    if (out_valid && out_ready) begin
      if (exp0.size() == 0) chk(0, "R4", 1, 0);
      else begin
        e0 = exp0.pop_front(); e1 = exp1.pop_front();
        chk(longint'(out_y0) == e0, tag_e, out_y0, e0);
        chk(longint'(out_y1) == e1, tag_o, out_y1, e1);
      end
    end
    hold = out_valid && !out_ready;
    hy0 = out_y0; hy1 = out_y1;
    prev_acc = in_valid && in_ready;
    if (prev_acc) begin
      xs.push_back(longint'(a)); xs.push_back(longint'(b));
      exp0.push_back(y_at(xs.size() - 2));
      exp1.push_back(y_at(xs.size() - 1));
    end
    prev_ov = out_valid; prev_or = out_ready;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R3", out_valid, 0);
    rst_n = 1;
    xs.delete(); exp0.delete(); exp1.delete();
    prev_acc = 0; prev_ov = 0; prev_or = 0; hold = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, '0, '0, 1);
    chk(exp0.size() == 0, "R4", exp0.size(), 0);
  endtask

  function automatic logic signed [DW-1:0] rnd();
    return DW'($urandom_range(0, 65535));
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: impulse returns coefficients in order
    do_reset();
    tag_e = "R8"; tag_o = "R8";
    step(1, 16'sd1, 16'sd0, 1);
    for (int i = 0; i < N/2 + 1; i++) step(1, '0, '0, 1);
    drain();

    // R3 then R1/R2: zero history after reset, full-rate random
    do_reset();
    tag_e = "R3"; tag_o = "R3";
    for (int i = 0; i < 4; i++) step(1, rnd(), rnd(), 1);
    tag_e = "R1"; tag_o = "R2";
    for (int i = 0; i < 60; i++) step(1, rnd(), rnd(), 1);
    drain();

    // R6 and R5: random gaps and back-pressure
    tag_e = "R6"; tag_o = "R6";
    for (int i = 0; i < 400; i++)
      step(($urandom_range(0, 3) != 0), rnd(), rnd(), ($urandom_range(0, 2) != 0));
    drain();

    // R7: full-scale patterns
    do_reset();
    tag_e = "R7"; tag_o = "R7";
    for (int i = 0; i < 12; i++) step(1, -16'sd32768, -16'sd32768, 1);
    for (int i = 0; i < 12; i++) step(1, 16'sd32767, 16'sd32767, 1);
    for (int i = 0; i < 12; i++) step(1, 16'sd32767, -16'sd32768, 1);
    for (int i = 0; i < 12; i++) step(1, -16'sd32768, 16'sd32767, ($urandom_range(0, 1) == 1));
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule